// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt for a processor. Each line is brought into the clock domain by a two-stage synchronizer. A rising edge on a line sets a bit in the status register. A software-owned enable register masks the status bits. The controller then looks at the enabled pending set and reports the most urgent source as a number, together with a valid flag. It also drives one interrupt line to the processor.

Sources are numbered big-endian. Request input `irq_req_i[j]` and data bit `j` of both registers belong to source number `31 - j`. Source 0 sits at data bit 31 and has the highest priority. Software reads and writes both registers through a small port with a one-bit address. Status bits are cleared by writing ones to them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, status and enable are cleared. After that edge, `irq_o` and `irq_id_vld_o` are low, `irq_id_o` is 0, and both registers read back 0.
- R2: A low-to-high transition on `irq_req_i[j]` sets status bit `j` once it has passed the two synchronizer flops. A request held high sets the bit only once: if software clears the bit while the line stays high, the bit stays clear.
- R3: A read with `reg_addr_i` = 0 returns the raw status bits on `reg_rdata_o` one cycle later, whatever the enable register holds.
- R4: A write with `reg_addr_i` = 1 loads all bits of the enable register, and a read at address 1 returns them one cycle later. A 1 at bit `j` unmasks source `31 - j`. Without such a write, enable keeps its value.
- R5: A write with `reg_addr_i` = 0 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R6: If a synchronized rising edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq_o` is high exactly one cycle after the AND of status and enable is non-zero, and low one cycle after it is zero.
- R8: When the enabled pending set is non-zero, `irq_id_vld_o` is high one cycle later. In that cycle `irq_id_o` equals 31 minus the highest set bit position of that set, so the smallest enabled pending source number wins. Masked sources never win.
- R9: When nothing enabled is pending, `irq_id_vld_o` is low and `irq_id_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | NUM_SRC (32) | Asynchronous request lines; bit j is source 31-j |
| reg_addr_i | input | 1 | Register select: 0 status, 1 enable |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | NUM_SRC (32) | Write data: enable value, or ones-to-clear for status |
| reg_rdata_o | output | NUM_SRC (32) | Registered read data of the selected register |
| irq_o | output | 1 | Interrupt to the processor |
| irq_id_o | output | ID_W (5) | Highest-priority enabled pending source number |
| irq_id_vld_o | output | 1 | `irq_id_o` holds a pending source |

## Verification
A synchronized request edge and a software clear can land on the same status bit in the same cycle. The bench provokes this by raising one request line and timing a clearing write to that bit. The write is placed exactly two clock edges after the line rises, which is the cycle in which the edge leaves the synchronizer. A readback of the status register must then show the bit still set. In the same way, a write to enable is followed by a check that the interrupt output rises one cycle later and not in the same cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_ENABLE = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/prio_irq_sync.sv
// Per-line synchronizer with rising-edge detector.
module prio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);

  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] shift_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shift_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        shift_q <= {shift_q[STAGES-2:0], async_i[g]};
        prev_q  <= shift_q[LAST];
      end
    end

    assign rise_o[g] = shift_q[LAST] & ~prev_q;
  end

endmodule

// File: rtl/prio_irq_regs.sv
// Status (set by edges, write-one-to-clear) and enable registers.
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               we_i,
  input  logic               addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] enable_o
);

  logic [NUM_SRC-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (we_i && (addr_i == REG_STATUS)) clr_mask = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      enable_o <= '0;
      rdata_o  <= '0;
    end else begin
      // a new edge overrides a clear in the same cycle
      status_o <= (status_o & ~clr_mask) | set_i;
      if (we_i && (addr_i == REG_ENABLE)) enable_o <= wdata_i;
      rdata_o <= (addr_i == REG_STATUS) ? status_o : enable_o;
    end
  end

endmodule

// File: rtl/prio_irq_enc.sv
// Big-endian priority encoder: the highest data bit is source 0 and wins.
module prio_irq_enc #(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic [ID_W-1:0]    id_o,
  output logic               hit_o
);

  always_comb begin
    id_o  = '0;
    hit_o = 1'b0;
    for (int p = 0; p < NUM_SRC; p++) begin
      if (vec_i[p]) begin
        id_o  = ID_W'(NUM_SRC - 1 - p);
        hit_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ID_W        = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic               reg_addr_i,
  input  logic               reg_we_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic               irq_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic               irq_id_vld_o
);

  logic [NUM_SRC-1:0] rise_vec;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] masked;
  logic [ID_W-1:0]    enc_id;
  logic               enc_hit;

  prio_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (irq_req_i),
    .rise_o  (rise_vec)
  );

  prio_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .set_i    (rise_vec),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .status_o (status_q),
    .enable_o (enable_q)
  );

  assign masked = status_q & enable_q;

  prio_irq_enc #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_enc (
    .vec_i (masked),
    .id_o  (enc_id),
    .hit_o (enc_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o        <= 1'b0;
      irq_id_o     <= '0;
      irq_id_vld_o <= 1'b0;
    end else begin
      irq_o        <= enc_hit;
      irq_id_o     <= enc_hit ? enc_id : '0;
      irq_id_vld_o <= enc_hit;
    end
  end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_addr_i,
  input logic               reg_we_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic [NUM_SRC-1:0] rise_vec,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic               irq_o,
  input logic [ID_W-1:0]    irq_id_o,
  input logic               irq_id_vld_o
);

  // R2
  status_from_edge_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_vec)) == '0));

  // R4
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we_i && reg_addr_i == REG_ENABLE) |=> $stable(enable_q));

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we_i && reg_addr_i == REG_STATUS && (reg_wdata_i & rise_vec) == '0)
      |=> ((status_q & $past(reg_wdata_i)) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_vec != '0) |=> ((status_q & $past(rise_vec)) == $past(rise_vec)));

  // R7
  irq_out_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == ($past(status_q & enable_q) != '0)));

  // R9
  idle_id_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_id_vld_o |-> (irq_id_o == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_addr_i   (reg_addr_i),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .rise_vec     (rise_vec),
  .status_q     (status_q),
  .enable_q     (enable_q),
  .irq_o        (irq_o),
  .irq_id_o     (irq_id_o),
  .irq_id_vld_o (irq_id_vld_o)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

  localparam int N  = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_req = '0;
  logic          reg_addr = 1'b0;
  logic          reg_we = 1'b0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          irq;
  logic [IW-1:0] irq_id;
  logic          irq_id_vld;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk          (clk),
    .rst          (rst),
    .irq_req_i    (irq_req),
    .reg_addr_i   (reg_addr),
    .reg_we_i     (reg_we),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .irq_o        (irq),
    .irq_id_o     (irq_id),
    .irq_id_vld_o (irq_id_vld)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    chk("R1 irq", N'(irq), 0);
    chk("R1 vld", N'(irq_id_vld), 0);
    chk("R1 id", N'(irq_id), 0);
    rd(1'b0, v); chk("R1 status", v, 0);
    rd(1'b1, v); chk("R1 enable", v, 0);
  endtask

  task automatic t_enable_rw();
    logic [N-1:0] v;
    wr(1'b1, 32'hA5A5_0F0F);
    rd(1'b1, v); chk("R4 enable readback", v, 32'hA5A5_0F0F);
    wr(1'b1, 32'h0);
    rd(1'b1, v); chk("R4 enable cleared", v, 0);
  endtask

  task automatic t_latch_masked();
    logic [N-1:0] v;
    @(negedge clk) irq_req[3] = 1'b1;
    wait_cyc(3);
    irq_req[3] = 1'b0;
    wait_cyc(4);
    rd(1'b0, v); chk("R2/R3 raw status", v, 32'h0000_0008);
    chk("R7 masked irq low", N'(irq), 0);
  endtask

  task automatic t_unmask_latency();
    wr(1'b1, 32'h0000_0008);
    chk("R7 irq not yet", N'(irq), 0);
    @(posedge clk); @(negedge clk);
    chk("R7 irq one cycle later", N'(irq), 1);
    chk("R8 vld", N'(irq_id_vld), 1);
    chk("R8 id source 28", N'(irq_id), 28);
  endtask

  task automatic t_priority();
    @(negedge clk) irq_req = 32'h0000_1010;
    wait_cyc(5);
    wr(1'b1, 32'hFFFF_FFFF);
    wait_cyc(2);
    chk("R8 id source 19", N'(irq_id), 19);
    wr(1'b1, ~32'h0000_1000);
    wait_cyc(2);
    chk("R8 masked skipped id 27", N'(irq_id), 27);
    @(negedge clk) irq_req[31] = 1'b1;
    wait_cyc(5);
    chk("R8 id source 0", N'(irq_id), 0);
    chk("R8 vld top", N'(irq_id_vld), 1);
  endtask

  task automatic t_w1c();
    logic [N-1:0] v;
    wr(1'b0, 32'h0);
    rd(1'b0, v); chk("R5 zero write no effect", v, 32'h8000_1018);
    wr(1'b0, 32'h0000_1000);
    rd(1'b0, v); chk("R5 one bit cleared", v, 32'h8000_0018);
    wr(1'b0, 32'hFFFF_FFFF);
    wait_cyc(4);
    rd(1'b0, v); chk("R2 held level no reset", v, 0);
    chk("R9 irq low", N'(irq), 0);
    chk("R9 vld low", N'(irq_id_vld), 0);
    chk("R9 id zero", N'(irq_id), 0);
  endtask

  task automatic t_collide();
    logic [N-1:0] v;
    @(negedge clk) irq_req = '0;
    wait_cyc(4);
    @(negedge clk) irq_req[20] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_addr = 1'b0; reg_wdata = 32'h0010_0000; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    rd(1'b0, v); chk("R6 set wins over clear", v, 32'h0010_0000);
    wait_cyc(1);
    chk("R8 id source 11", N'(irq_id), 11);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_enable_rw();
    t_latch_masked();
    t_unmask_latency();
    t_priority();
    t_w1c();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule